// File: doc/BRIEF.md
# Dual-Path Level Interrupt Controller

This block gathers level-sensitive interrupt sources and presents them to a processor on two lines: a normal interrupt request and a fast interrupt request. Each line has its own enable mask, so software can route any source to either line, to both, or to neither. Software changes a mask through two word addresses: one turns on the bits written as one, the other turns them off. This avoids read-modify-write sequences.

Software reads each path's state in two forms. The unmasked form shows every source. The masked form shows only the sources that are enabled on that path. Source 0 also has a software latch. Software can set and clear it, and it is ORed with hardware line 0, so neither one overwrites the other. The block does no priority encoding, vectoring or edge detection.

The register bus is word-indexed. A write takes effect at the clock edge where the write strobe is high. Read data is registered and shows the word for the index that was presented one cycle earlier. Both interrupt lines are registered as well.

Top module: `irq_fiq_intc`

## Requirements
- R1: Word index 1 and word index 9 both read the source levels without masking. Bit n of this value is source n. Bit 0 is the OR of input line 0 and the software latch.
- R2: A write to index 2 ORs the write data into the normal-path enable mask. A read of index 2 returns that mask.
- R3: A write to index 3 clears every normal-path enable bit that is set in the write data. Other bits keep their value.
- R4: Indices 10 and 11 do for the fast-path mask what indices 2 and 3 do for the normal-path mask. Writes to either mask never change the other mask.
- R5: Index 0 reads the source levels ANDed with the normal-path mask. Index 8 reads the source levels ANDed with the fast-path mask.
- R6: A write to index 4 with data bit 0 set sets the software latch. A write to index 5 with data bit 0 set clears it. Writes with data bit 0 clear have no effect. A read of index 4 returns source bit 0 in bit 0 and zero in all other bits.
- R7: On every clock edge, `irq_out` is loaded with whether any source is both asserted and enabled on the normal path. `fiq_out` is loaded the same way for the fast path. Each output therefore follows an input or mask change one cycle later.
- R8: Reads of indices 3, 5, 11, 6, 7 and 12 to 15 return zero. Writes to indices 0, 1, 8, 9, 6, 7 and 12 to 15 change no mask and do not change the software latch.
- R9: Synchronous reset clears both masks, the software latch, both outputs and the read data.
- R10: `bus_rdata` shows the word for the index presented on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Level-sensitive source lines |
| bus_idx | input | 4 | Word index of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Registered read data |
| irq_out | output | 1 | Normal interrupt request, registered |
| fiq_out | output | 1 | Fast interrupt request, registered |

## Verification
After each stimulus, the bench reads all sixteen word indices and checks both output lines.

- A walking single-bit source pattern runs against two masks that do not overlap. This shows that each bit position reaches the correct column of each register, and that each path masks independently.
- Pseudo-random sources and masks exercise mixed overlaps. Set and clear writes with scattered bits show that the two write styles differ.
- Writes with data bit 0 clear, and writes to read-only and unused indices, show that stray writes leave all state unchanged.
- Setting the software latch while input line 0 is held high, and also while it is low, shows that the latch is ORed with the line and does not replace it.
- One source edge is timed against the clock to confirm the one-cycle output latency.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int IDX_W = 4;

  // low three index bits select the register within a path; bit 3 selects the path
  localparam logic [2:0] OFS_MASKED  = 3'd0;
  localparam logic [2:0] OFS_RAW     = 3'd1;
  localparam logic [2:0] OFS_EN_SET  = 3'd2;
  localparam logic [2:0] OFS_EN_CLR  = 3'd3;
  localparam logic [2:0] OFS_SW_SET  = 3'd4;
  localparam logic [2:0] OFS_SW_CLR  = 3'd5;

  typedef enum logic {PATH_NORM = 1'b0, PATH_FAST = 1'b1} path_e;
  localparam int NUM_PATHS = 2;
endpackage

// File: rtl/intc_mask_bank.sv
`timescale 1ns/1ps
module intc_mask_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)          mask <= '0;
    else if (set_stb) mask <= mask | wdata;
    else if (clr_stb) mask <= mask & ~wdata;
  end

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> ((mask & $past(wdata)) == $past(wdata)));
  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !set_stb) |=> ((mask & $past(wdata)) == '0));
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_stb && !clr_stb) |=> $stable(mask));
endmodule

// File: rtl/intc_src_level.sv
`timescale 1ns/1ps
module intc_src_level #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_in,
  input  logic         sw_set,
  input  logic         sw_clr,
  output logic [W-1:0] level
);
  logic sw_latch;

  always_ff @(posedge clk) begin
    if (rst)         sw_latch <= 1'b0;
    else if (sw_set) sw_latch <= 1'b1;
    else if (sw_clr) sw_latch <= 1'b0;
  end

  assign level = src_in | {{(W-1){1'b0}}, sw_latch};

  // R6
  sw_set_chk: assert property (@(posedge clk) disable iff (rst)
    sw_set |=> level[0]);
  // R6
  sw_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_clr && !sw_set) |=> (level[0] == src_in[0]));
endmodule

// File: rtl/intc_read_port.sv
`timescale 1ns/1ps
module intc_read_port
  import intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     level,
  input  logic [W-1:0]     en_norm,
  input  logic [W-1:0]     en_fast,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] sel_en;
  logic [W-1:0] word;

  assign sel_en = (idx[3] == PATH_FAST) ? en_fast : en_norm;

  always_comb begin
    word = '0;
    unique case (idx[2:0])
      OFS_MASKED: word = level & sel_en;
      OFS_RAW:    word = level;
      OFS_EN_SET: word = sel_en;
      OFS_SW_SET: if (idx[3] == PATH_NORM) word = {{(W-1){1'b0}}, level[0]};
      default:    word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= word;
  end

  // R1
  raw_view_chk: assert property (@(posedge clk) disable iff (rst)
    (idx == 4'd1 || idx == 4'd9) |=> (rdata == $past(level)));
  // R8
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (idx == 4'd3 || idx == 4'd5 || idx == 4'd11) |=> (rdata == '0));
endmodule

// File: rtl/irq_fiq_intc.sv
`timescale 1ns/1ps
module irq_fiq_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [IDX_W-1:0]   bus_idx,
  input  logic               bus_we,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_out,
  output logic               fiq_out
);
  logic [NUM_SRC-1:0]   level;
  logic [NUM_SRC-1:0]   en_mask [NUM_PATHS];
  logic [NUM_PATHS-1:0] line_q;
  logic                 sw_set, sw_clr;

  assign sw_set = bus_we && (bus_idx == {PATH_NORM, OFS_SW_SET}) && bus_wdata[0];
  assign sw_clr = bus_we && (bus_idx == {PATH_NORM, OFS_SW_CLR}) && bus_wdata[0];

  intc_src_level #(.W(NUM_SRC)) u_src (
    .clk(clk), .rst(rst), .src_in(src_in),
    .sw_set(sw_set), .sw_clr(sw_clr), .level(level)
  );

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    logic hit;
    assign hit = bus_we && (bus_idx[3] == 1'(g));

    intc_mask_bank #(.W(NUM_SRC)) u_mask (
      .clk(clk), .rst(rst),
      .set_stb(hit && bus_idx[2:0] == OFS_EN_SET),
      .clr_stb(hit && bus_idx[2:0] == OFS_EN_CLR),
      .wdata(bus_wdata), .mask(en_mask[g])
    );

    always_ff @(posedge clk) begin
      if (rst) line_q[g] <= 1'b0;
      else     line_q[g] <= |(level & en_mask[g]);
    end
  end

  assign irq_out = line_q[PATH_NORM];
  assign fiq_out = line_q[PATH_FAST];

  intc_read_port #(.W(NUM_SRC)) u_rd (
    .clk(clk), .rst(rst), .idx(bus_idx), .level(level),
    .en_norm(en_mask[PATH_NORM]), .en_fast(en_mask[PATH_FAST]),
    .rdata(bus_rdata)
  );

  // R9
  out_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_out && !fiq_out && bus_rdata == '0));
  // R7
  irq_masked_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((level & en_mask[PATH_NORM]) == '0) |=> !irq_out);
endmodule

// File: tb/test_irq_fiq_intc.sv
`timescale 1ns/1ps
module test_irq_fiq_intc;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src_in = '0;
  logic [3:0]   bus_idx = '0;
  logic         bus_we = 1'b0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         irq_out, fiq_out;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_ien = '0, m_fen = '0;
  logic         m_sw = 1'b0;
  logic [31:0]  seed = 32'h1234_5678;

  irq_fiq_intc #(.NUM_SRC(N)) i_irq_fiq_intc (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_idx(bus_idx), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  always #2.5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired actual=%0d expected<%0d", 100000, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [N-1:0] raw_lvl();
    return src_in | {{(N-1){1'b0}}, m_sw};
  endfunction

  function automatic logic [N-1:0] exp_word(input int ix);
    logic [N-1:0] r = raw_lvl();
    case (ix)
      0: return r & m_ien;
      1, 9: return r;
      2: return m_ien;
      4: return {{(N-1){1'b0}}, r[0]};
      8: return r & m_fen;
      10: return m_fen;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input int ix);
    case (ix)
      0, 8: return "R5";
      1, 9: return "R1";
      2: return "R2";
      10: return "R4";
      4: return "R6";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ix, input logic [N-1:0] d);
    @(negedge clk);
    bus_idx = 4'(ix); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    case (ix)
      2: m_ien |= d;
      3: m_ien &= ~d;
      10: m_fen |= d;
      11: m_fen &= ~d;
      4: if (d[0]) m_sw = 1'b1;
      5: if (d[0]) m_sw = 1'b0;
      default: ;
    endcase
  endtask

  // R10: read data sampled on the negedge after the edge that captured the index
  task automatic sweep_all();
    for (int ix = 0; ix < 16; ix++) begin
      @(negedge clk);
      bus_idx = 4'(ix);
      @(negedge clk);
      check(tag_of(ix), bus_rdata, exp_word(ix));
    end
    check("R7 irq", N'(irq_out), N'(|(raw_lvl() & m_ien)));
    check("R7 fiq", N'(fiq_out), N'(|(raw_lvl() & m_fen)));
  endtask

  initial begin
    src_in = '1;
    repeat (3) @(negedge clk);
    check("R9 rdata", bus_rdata, '0);
    check("R9 irq", N'(irq_out), '0);
    check("R9 fiq", N'(fiq_out), '0);
    rst = 1'b0;
    src_in = '0;
    sweep_all();

    // walking one against disjoint masks
    wr(2, 32'h0000_FFFF);
    wr(10, 32'hFFFF_0000);
    for (int i = 0; i < N; i++) begin
      @(negedge clk); src_in = N'(1) << i;
      sweep_all();
    end

    // R3 / R4: clears touch only written bits and only their own path
    wr(3, 32'h0000_00F0);
    wr(11, 32'h0F00_0000);
    src_in = 32'hFFFF_FFFF;
    sweep_all();

    // R6: latch behaviour, bit-0 qualification, OR with line 0
    src_in = '0;
    wr(4, 32'hFFFF_FFFE);
    sweep_all();
    wr(4, 32'h0000_0001);
    sweep_all();
    wr(5, 32'hFFFF_FFFE);
    sweep_all();
    src_in = 32'h1;
    wr(5, 32'h1);
    sweep_all();
    src_in = '0;
    sweep_all();

    // R8: stray writes change nothing
    wr(4, 32'h1);
    foreach (i_list[k]) wr(i_list[k], 32'hFFFF_FFFF);
    sweep_all();
    wr(5, 32'h1);

    // R7: one-cycle output latency
    wr(3, '1); wr(11, '1);
    wr(2, 32'h8); wr(10, 32'h8);
    @(negedge clk); src_in = 32'h8;
    #1;
    check("R7 latency irq low", N'(irq_out), '0);
    check("R7 latency fiq low", N'(fiq_out), '0);
    @(negedge clk);
    check("R7 latency irq high", N'(irq_out), N'(1));
    check("R7 latency fiq high", N'(fiq_out), N'(1));

    // pseudo-random sources and masks
    for (int t = 0; t < 40; t++) begin
      wr(3, '1); wr(11, '1);
      seed = next_rand(seed); wr(2, seed);
      seed = next_rand(seed); wr(10, seed & {N{t[0]}} | (seed >> (t % 7)));
      seed = next_rand(seed);
      @(negedge clk); src_in = seed & next_rand(seed);
      sweep_all();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int i_list [10] = '{0, 1, 8, 9, 6, 7, 12, 13, 14, 15};
endmodule